// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave device has left stuck, typically by holding SDA low part way through a byte after an interrupted transfer. When a start strobe arrives while the block is idle, it takes ownership of both bus lines as open-drain drivers. It keeps SDA released and clocks SCL nine times, which is enough to walk any slave through the rest of an address, direction and acknowledge frame. It then synthesises a STOP condition so that every device on the bus sees the bus become free.

Before each clock pulse the block checks whether SCL has actually gone high. If a slave is stretching the clock, the block waits, but only for a bounded time, and then issues the pulse anyway. All timing is taken from one prescaler that divides the system clock down to a half-period step of the recovery clock. The block reports that it is running with a busy flag and signals completion with a single-cycle done pulse. A bus controller or a supervisor would fire it after it has decided the bus is stuck.

Top module: `i2c_bus_unjam`

## Requirements
- R1: A synchronous active-high reset leaves scl_oe, sda_oe, busy and done all low from the first clock edge on which it is sampled.
- R2: A start strobe seen while idle sets busy on that clock edge. Both lines then stay released (scl_oe = 0, sda_oe = 0) for one half period, H = (CLK_FREQ_HZ / 1000000) * HALF_US cycles.
- R3: The block drives exactly nine SCL low pulses while sda_oe stays 0 throughout. Each pulse holds scl_oe = 1 for exactly H cycles.
- R4: After each pulse SCL is released for H cycles. The next pulse starts on the first clock edge at which the sampled SCL input reads high, so that an unstretched pulse period is 2H + 1 cycles.
- R5: While a slave holds SCL low before a pulse, the block waits for at most 2 * STRETCH_POLLS half periods. It then drives the pulse even if SCL is still low.
- R6: After the ninth pulse the STOP runs in this order, with H cycles between steps: drive SCL low, drive SDA low, release SCL, release SDA. SDA is never driven low unless SCL is driven low at the same time.
- R7: done is high for exactly one cycle, on the same edge that releases SDA and clears busy. With no stretching, that edge comes 22H + 9 cycles after the start edge.
- R8: A start strobe that arrives while busy has no effect. The job's timing is unchanged and exactly one done pulse follows.
- R9: While busy is low, both scl_oe and sda_oe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle strobe that requests a recovery sequence |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
Every result is a registered output, so it is due on a known edge counted from the start edge. Busy rises on the start edge itself. Each SCL low phase lasts H cycles. A pulse begins one edge after SCL reads high, or 2 * STRETCH_POLLS half periods after the check began when SCL stays low. Done lands 22H + 9 edges after start without stretching, 40 edges later when a stretch is released 40 edges into the first check, and 922H edges after start when SCL is held low throughout. The bench drives its inputs on falling edges and samples the outputs there. It keeps a cycle counter that advances on rising edges, and it compares the counter at the done pulse, and every pulse width, against these closed-form figures.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PREP  = 3'd1,
    ST_CHECK = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4,
    ST_STOPA = 3'd5,
    ST_STOPB = 3'd6,
    ST_STOPC = 3'd7
  } unjam_state_e;

endpackage

// File: rtl/unjam_tick.sv
module unjam_tick #(
  parameter int TICK_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/unjam_seq.sv
module unjam_seq
  import i2c_unjam_pkg::*;
#(
  parameter int NUM_PULSES    = 9,
  parameter int STRETCH_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic scl_in,
  input  logic tick,
  output logic restart,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam int SW = (STRETCH_TICKS > 1) ? $clog2(STRETCH_TICKS) : 1;
  localparam logic [PW-1:0] PULSE_LAST   = PW'(NUM_PULSES - 1);
  localparam logic [SW-1:0] STRETCH_LAST = SW'(STRETCH_TICKS - 1);

  unjam_state_e  st;
  logic [PW-1:0] pulse_cnt;
  logic [SW-1:0] wait_cnt;
  logic          launch;
  logic          check_exit;

  assign launch     = (st == ST_IDLE) && start_i;
  assign check_exit = (st == ST_CHECK) &&
                      (scl_in || (tick && (wait_cnt == STRETCH_LAST)));
  assign restart    = launch || check_exit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pulse_cnt <= '0;
      wait_cnt  <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (start_i) begin
            busy      <= 1'b1;
            pulse_cnt <= '0;
            wait_cnt  <= '0;
            st        <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (tick) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (check_exit) begin
            scl_oe   <= 1'b1;
            wait_cnt <= '0;
            st       <= ST_LOW;
          end else if (tick) begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (tick) begin
            scl_oe <= 1'b0;
            st     <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (pulse_cnt == PULSE_LAST) begin
              scl_oe <= 1'b1;
              st     <= ST_STOPA;
            end else begin
              pulse_cnt <= pulse_cnt + 1'b1;
              st        <= ST_CHECK;
            end
          end
        end
        ST_STOPA: begin
          if (tick) begin
            sda_oe <= 1'b1;
            st     <= ST_STOPB;
          end
        end
        ST_STOPB: begin
          if (tick) begin
            scl_oe <= 1'b0;
            st     <= ST_STOPC;
          end
        end
        ST_STOPC: begin
          if (tick) begin
            sda_oe <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int CLK_FREQ_HZ   = 250_000_000,
  parameter int HALF_US       = 5,
  parameter int NUM_PULSES    = 9,
  parameter int STRETCH_POLLS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic scl_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  localparam int HALF_CYCLES   = (CLK_FREQ_HZ / 1_000_000) * HALF_US;
  localparam int STRETCH_TICKS = 2 * STRETCH_POLLS;

  logic tick;
  logic restart;

  unjam_tick #(
    .TICK_CYCLES(HALF_CYCLES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .tick   (tick)
  );

  unjam_seq #(
    .NUM_PULSES   (NUM_PULSES),
    .STRETCH_TICKS(STRETCH_TICKS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .scl_in (scl_in),
    .tick   (tick),
    .restart(restart),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done)
  );
endmodule

// File: rtl/i2c_bus_unjam_chk.sv
module i2c_bus_unjam_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !scl_oe && !sda_oe));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R6
  sda_low_needs_scl_chk: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> scl_oe);

  // R6
  sda_release_last_chk: assert property (@(posedge clk) disable iff (rst) $fell(sda_oe) |-> (!scl_oe && done));

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!scl_oe && !sda_oe));

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst) (!busy && start_i) |=> busy);

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst) (busy && start_i && !done) |=> (busy || done));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .scl_oe (scl_oe),
  .sda_oe (sda_oe),
  .busy   (busy),
  .done   (done)
);

// File: tb/i2c_bus_unjam_tb.sv
`timescale 1ns/1ps
module i2c_bus_unjam_tb_top;
  localparam int FREQ = 4_000_000;
  localparam int HUS  = 5;
  localparam int H    = (FREQ / 1_000_000) * HUS;
  localparam int POLLS = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic hold = 1'b0;
  logic scl_in;
  logic scl_oe, sda_oe, busy, done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = ~scl_oe & ~hold;

  i2c_bus_unjam #(
    .CLK_FREQ_HZ  (FREQ),
    .HALF_US      (HUS),
    .NUM_PULSES   (9),
    .STRETCH_POLLS(POLLS)
  ) dut_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .scl_in (scl_in),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one job and checks pulse count, widths, STOP order and latency.
  task automatic run_job(input int exp_lat, input int release_at, input bit stuck,
                         input int restart_at, input string tag);
    int k, lat, pulses, width, bad_width, order_bad, dones, prep_bad;
    bit pscl, psda, stop_seen;
    pulses = 0; width = 0; bad_width = 0; order_bad = 0; dones = 0; prep_bad = 0;
    pscl = 1'b0; psda = 1'b0; stop_seen = 1'b0; lat = -1;
    hold = (release_at > 0) || stuck;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = cyc;
    // R2: busy set on the start edge, lines released
    chk(busy == 1'b1 && !scl_oe && !sda_oe, {tag, " R2 busy after start"}, busy, 1);
    while (cyc - k < 30000) begin
      if (cyc - k < H && (scl_oe || sda_oe)) prep_bad++;
      if (scl_oe) width++;
      if (pscl && !scl_oe && !psda && !sda_oe) begin
        pulses++;
        if (width != H) bad_width++;
      end
      if (!scl_oe) width = 0;
      if (sda_oe && !psda) begin
        stop_seen = 1'b1;
        if (!scl_oe || pulses != 9) order_bad++;
      end
      if (!sda_oe && psda && (scl_oe || !done)) order_bad++;
      if (sda_oe && !stop_seen) order_bad++;
      if (done) begin
        dones++;
        if (busy) order_bad++;
        lat = cyc - k;
        break;
      end
      pscl = scl_oe;
      psda = sda_oe;
      if (release_at > 0 && cyc == k + release_at) hold = 1'b0;
      start_i = (restart_at > 0 && cyc == k + restart_at);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(prep_bad == 0, {tag, " R2 prep released"}, prep_bad, 0);
    chk(pulses == 9, {tag, " R3 pulse count"}, pulses, 9);
    chk(bad_width == 0, {tag, " R3 low width"}, bad_width, 0);
    chk(order_bad == 0, {tag, " R6 stop order"}, order_bad, 0);
    chk(lat == exp_lat, {tag, " R7 done latency"}, lat, exp_lat);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R7 done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    // R9: idle and released afterwards
    chk(!busy && !scl_oe && !sda_oe, {tag, " R9 idle released"}, busy, 0);
    hold = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state", busy, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic();
    run_job(22 * H + 9, 0, 1'b0, 0, "basic R4 R9");
  endtask

  task automatic t_stretch_release();
    // R4: release 40 edges into the first check adds 40 cycles
    run_job(22 * H + 49, H + 40, 1'b0, 0, "stretch R4");
  endtask

  task automatic t_stretch_timeout();
    // R5: SCL held low forever; each check times out after 2*POLLS halves
    run_job(922 * H, 0, 1'b1, 0, "timeout R5");
  endtask

  task automatic t_restart_ignored();
    // R8: second start mid-run changes nothing
    run_job(22 * H + 9, 0, 1'b0, 5 * H, "ignore R8");
  endtask

  task automatic t_reset_midrun();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3 * H + 4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    // R1
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset mid-run", busy, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !scl_oe, "R1 stays idle", busy, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stretch_release();
    t_restart_ignored();
    t_stretch_timeout();
    t_reset_midrun();
    t_basic();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule